// File: doc/BRIEF.md
# Interrupt Distributor Control Registers

This block is the small group of global registers at the bottom of an interrupt distributor's register space. A simple 32-bit register bus reaches it. It holds the distributor's master enable. It also answers reads of two constant words. The first is a type word that reports how many interrupt lines and how many CPUs the distributor was built for. The second is an identification word that carries a product code and an implementer code.

Software sets the master enable by writing the control word. The moment the enable goes from off to on, the block sends a single-cycle wake pulse to every CPU interface, so that each one looks at its pending interrupts again. Reads are registered: read data shows up one clock after the read strobe and then holds until the next read. The register window is three words long. The bus carries only the word index, which is byte-offset bits [3:2], so byte-lane bits never take part in decode.

Top module: `irq_dist_ctrl_regs`

## Requirements
- R1: During and right after a synchronous active-high reset, the enable is 0, every wake output is 0 and the read data is 0.
- R2: A read at word index 0 (control) returns the enable in bit 0 and zero in bits [31:1].
- R3: A write at word index 0 loads write-data bit 0 into the enable on that clock edge. Write-data bits [31:1] have no effect.
- R4: A read at word index 1 (type) returns (SHARED_IRQS + 32) / 32 − 1 in bits [4:0].
- R5: In the type word, bits [7:5] hold NUM_CPUS − 1 and bits [31:8] are zero.
- R6: A read at word index 2 (identification) returns PRODUCT_CODE in bits [31:24] and IMPL_CODE in bits [11:0], with all other bits zero.
- R7: A read at word index 3 returns zero. Writes at word indices 1, 2 and 3 leave the enable unchanged.
- R8: A control write that takes the enable from 0 to 1 drives every bit of the wake output to 1 for exactly one cycle, in the cycle after the write edge.
- R9: No wake bit is set when a control write leaves the enable at 1 or writes 0, or when there is no control write.
- R10: Read data changes only on a read strobe. A read that happens in the same cycle as a write returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_word | input | 2 | Word index (byte-offset bits [3:2]) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after reg_rd |
| dist_en | output | 1 | Current master enable |
| cpu_wake | output | NUM_CPUS | One-cycle wake pulse, one bit per CPU interface |

## Verification
The bench goes after the enable edge cases. It writes 1 while the enable is already 1, where a design that detects levels instead of edges would wake the CPUs again. It writes with only upper data bits set, where a design that tests the whole word would turn on. It writes to the constant words and to the unused fourth word, where a decoder that ignores the index would clobber the enable. A read and a write in the same cycle must return the old enable, which exposes a mux fed from the next-state value. The type and identification words are compared field by field, which catches off-by-one CPU or line counts and fields placed at the wrong bit position.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

  localparam int REG_W  = 32;
  localparam int WORD_W = 2;

  typedef enum logic [WORD_W-1:0] {
    SEL_CTRL  = 2'd0,
    SEL_TYPE  = 2'd1,
    SEL_IDENT = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  function automatic logic [REG_W-1:0] make_type_word(input int ncpu, input int shared_irqs);
    logic [REG_W-1:0] w;
    w = '0;
    w[4:0] = 5'((shared_irqs + 32) / 32 - 1);
    w[7:5] = 3'(ncpu - 1);
    return w;
  endfunction

  function automatic logic [REG_W-1:0] make_ident_word(input logic [7:0] prod, input logic [11:0] impl);
    logic [REG_W-1:0] w;
    w = '0;
    w[31:24] = prod;
    w[11:0]  = impl;
    return w;
  endfunction

endpackage

// File: rtl/dist_reg_decode.sv
module dist_reg_decode
  import irq_dist_pkg::*;
(
  input  logic [WORD_W-1:0] word_idx,
  input  logic              wr_stb,
  output reg_sel_e          sel,
  output logic              ctrl_wr
);

  always_comb begin
    unique case (word_idx)
      2'd0:    sel = SEL_CTRL;
      2'd1:    sel = SEL_TYPE;
      2'd2:    sel = SEL_IDENT;
      default: sel = SEL_NONE;
    endcase
  end

  assign ctrl_wr = wr_stb && (sel == SEL_CTRL);

endmodule

// File: rtl/dist_enable_ctrl.sv
module dist_enable_ctrl #(
  parameter int NUM_CPUS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ctrl_wr,
  input  logic                en_bit,
  output logic                en_q,
  output logic [NUM_CPUS-1:0] wake_q
);

  logic turn_on;
  assign turn_on = ctrl_wr && en_bit && !en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      wake_q <= '0;
    end else begin
      if (ctrl_wr) en_q <= en_bit;
      wake_q <= {NUM_CPUS{turn_on}};
    end
  end

  a_r8_wake_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> (wake_q == {NUM_CPUS{1'b1}}));

  a_r8_single_cycle: assert property (@(posedge clk) disable iff (rst)
    wake_q[0] |=> !wake_q[0]);

  a_r9_no_spurious_wake: assert property (@(posedge clk) disable iff (rst)
    (wake_q != '0) |-> $rose(en_q));

  a_r8_all_or_none: assert property (@(posedge clk) disable iff (rst)
    (wake_q == '0) || (wake_q == {NUM_CPUS{1'b1}}));

endmodule

// File: rtl/dist_rdata_mux.sv
module dist_rdata_mux
  import irq_dist_pkg::*;
#(
  parameter int         NUM_CPUS     = 4,
  parameter int         SHARED_IRQS  = 64,
  parameter logic [7:0] PRODUCT_CODE = 8'h5A,
  parameter logic [11:0] IMPL_CODE   = 12'h3C1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_stb,
  input  reg_sel_e         sel,
  input  logic             en,
  output logic [REG_W-1:0] rdata_q
);

  localparam logic [REG_W-1:0] TYPE_WORD  = make_type_word(NUM_CPUS, SHARED_IRQS);
  localparam logic [REG_W-1:0] IDENT_WORD = make_ident_word(PRODUCT_CODE, IMPL_CODE);

  logic [REG_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_CTRL:  rd_mux[0] = en;
      SEL_TYPE:  rd_mux = TYPE_WORD;
      SEL_IDENT: rd_mux = IDENT_WORD;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (rd_stb) rdata_q <= rd_mux;
  end

  a_r10_hold_without_read: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rdata_q));

  a_r2_ctrl_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && sel == SEL_CTRL) |=> (rdata_q[REG_W-1:1] == '0));

endmodule

// File: rtl/irq_dist_ctrl_regs.sv
module irq_dist_ctrl_regs
  import irq_dist_pkg::*;
#(
  parameter int          NUM_CPUS     = 4,
  parameter int          SHARED_IRQS  = 64,
  parameter logic [7:0]  PRODUCT_CODE = 8'h5A,
  parameter logic [11:0] IMPL_CODE    = 12'h3C1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_rd,
  input  logic                reg_wr,
  input  logic [1:0]          reg_word,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                dist_en,
  output logic [NUM_CPUS-1:0] cpu_wake
);

  reg_sel_e sel;
  logic     ctrl_wr;
  logic     wdata_hi_any;

  assign wdata_hi_any = |reg_wdata[31:1];

  dist_reg_decode u_decode (
    .word_idx (reg_word),
    .wr_stb   (reg_wr),
    .sel      (sel),
    .ctrl_wr  (ctrl_wr)
  );

  dist_enable_ctrl #(.NUM_CPUS(NUM_CPUS)) u_enable (
    .clk     (clk),
    .rst     (rst),
    .ctrl_wr (ctrl_wr),
    .en_bit  (reg_wdata[0]),
    .en_q    (dist_en),
    .wake_q  (cpu_wake)
  );

  dist_rdata_mux #(
    .NUM_CPUS     (NUM_CPUS),
    .SHARED_IRQS  (SHARED_IRQS),
    .PRODUCT_CODE (PRODUCT_CODE),
    .IMPL_CODE    (IMPL_CODE)
  ) u_rmux (
    .clk     (clk),
    .rst     (rst),
    .rd_stb  (reg_rd),
    .sel     (sel),
    .en      (dist_en),
    .rdata_q (reg_rdata)
  );

  a_r7_other_writes_ignored: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_word != 2'd0) |=> $stable(dist_en));

  a_r3_ctrl_write_loads: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_word == 2'd0) |=> (dist_en == $past(reg_wdata[0])));

  a_r3_upper_bits_ignored: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_word == 2'd0 && wdata_hi_any && !reg_wdata[0]) |=> !dist_en);

  a_r9_no_wake_when_set: assert property (@(posedge clk) disable iff (rst)
    dist_en |=> (cpu_wake == '0));

endmodule

// File: tb/sim_irq_dist_ctrl_regs.sv
module sim_irq_dist_ctrl_regs;

  localparam int          NCPU  = 4;
  localparam int          NSHR  = 64;
  localparam logic [7:0]  PROD  = 8'h5A;
  localparam logic [11:0] IMPL  = 12'h3C1;

  logic              clk = 1'b0;
  logic              rst;
  logic              reg_rd, reg_wr;
  logic [1:0]        reg_word;
  logic [31:0]       reg_wdata;
  logic [31:0]       reg_rdata;
  logic              dist_en;
  logic [NCPU-1:0]   cpu_wake;

  int checks = 0;
  int errors = 0;
  logic model_en;
  logic [31:0] model_rd;

  always #2 clk = ~clk;

  irq_dist_ctrl_regs #(
    .NUM_CPUS(NCPU), .SHARED_IRQS(NSHR), .PRODUCT_CODE(PROD), .IMPL_CODE(IMPL)
  ) u0 (
    .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_word(reg_word),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dist_en(dist_en), .cpu_wake(cpu_wake)
  );

  function automatic logic [31:0] exp_read(input logic [1:0] w, input logic en);
    logic [31:0] v;
    v = '0;
    case (w)
      2'd0: v[0] = en;
      2'd1: begin
        v[4:0] = 5'((NSHR + 32) / 32 - 1);
        v[7:5] = 3'(NCPU - 1);
      end
      2'd2: begin
        v[31:24] = PROD;
        v[11:0]  = IMPL;
      end
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, sample 1 ns after posedge, compare with model.
  task automatic bus_op(input logic rd, input logic wr, input logic [1:0] w,
                        input logic [31:0] d, input string req);
    logic [NCPU-1:0] exp_wake;
    @(negedge clk);
    reg_rd = rd; reg_wr = wr; reg_word = w; reg_wdata = d;
    exp_wake = '0;
    if (rd) model_rd = exp_read(w, model_en);
    if (wr && w == 2'd0) begin
      if (d[0] && !model_en) exp_wake = '1;
      model_en = d[0];
    end
    @(posedge clk);
    #1;
    chk({req, " enable"}, 32'(dist_en), 32'(model_en));
    chk({req, " wake"},   32'(cpu_wake), 32'(exp_wake));
    chk({req, " rdata"},  reg_rdata, model_rd);
    @(negedge clk);
    reg_rd = 1'b0; reg_wr = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst = 1'b1; reg_rd = 0; reg_wr = 0; reg_word = 0; reg_wdata = 0;
    model_en = 0; model_rd = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset enable", 32'(dist_en), 0);
    chk("R1 reset wake", 32'(cpu_wake), 0);
    chk("R1 reset rdata", reg_rdata, 0);
    @(negedge clk); rst = 1'b0;

    bus_op(1, 0, 2'd0, 0, "R2 ctrl read off");
    bus_op(1, 0, 2'd1, 0, "R4 R5 type read");
    chk("R4 type lines", 32'(reg_rdata[4:0]), 2);
    chk("R5 type cpus", 32'(reg_rdata[7:5]), 3);
    chk("R5 type upper", 32'(reg_rdata[31:8]), 0);
    bus_op(1, 0, 2'd2, 0, "R6 ident read");
    chk("R6 ident value", reg_rdata, 32'h5A0003C1);
    bus_op(1, 0, 2'd3, 0, "R7 unused read");
    bus_op(0, 1, 2'd0, 32'hFFFF_FFFE, "R3 upper bits only");
    bus_op(0, 1, 2'd1, 32'h1, "R7 type write");
    bus_op(0, 1, 2'd2, 32'h1, "R7 ident write");
    bus_op(0, 1, 2'd3, 32'h1, "R7 unused write");
    bus_op(1, 0, 2'd1, 0, "R7 type after write");
    bus_op(0, 1, 2'd0, 32'h1, "R8 enable rise");
    bus_op(0, 0, 2'd0, 0, "R8 pulse ends");
    bus_op(0, 1, 2'd0, 32'h1, "R9 rewrite one");
    bus_op(1, 0, 2'd0, 0, "R2 ctrl read on");
    bus_op(1, 1, 2'd0, 32'h0, "R10 read with clear");
    bus_op(0, 0, 2'd1, 0, "R10 hold");
    bus_op(0, 1, 2'd0, 32'h0, "R9 write zero");
    bus_op(1, 1, 2'd0, 32'h1, "R8 R10 read with set");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      bus_op(r[0], r[1], r[3:2], (r[4] ? $urandom : {31'(0), r[5]}), "R2 R3 R7 R8 R9 R10 random");
    end

    @(negedge clk); rst = 1'b1; model_en = 0; model_rd = 0;
    @(posedge clk); #1;
    chk("R1 mid reset enable", 32'(dist_en), 0);
    chk("R1 mid reset rdata", reg_rdata, 0);
    @(negedge clk); rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule